// File: doc/BRIEF.md
# DDR Prefetch Data Gearbox

This block sits between a memory core that handles one double-width word per core clock and a pin interface that moves one lane-width beat on each half of that clock. In the write direction it watches a per-byte data strobe and takes one beat on the strobe's rising transition and one on its falling transition. It joins the two beats, with their byte masks, into one core word. In the read direction it takes a core word and sends it out as two beats. A strobe edge leaves with each beat. The strobe is framed by one preamble half-cycle before the burst and one postamble half-cycle after it.

The logic runs on a single clock at twice the core rate, so one fast cycle is one half core cycle. Pin signals are sampled and driven once per fast cycle. The lane width is a parameter (4, 8 or 16). Each group of up to eight lanes has its own strobe and mask bit, and each group captures independently of the others. A 2-bit burst-length code sets the number of core words per burst.

Top module: `ddr_prefetch_gearbox`

## Requirements
- R1: While reset is high and just after it, every output enable, every write valid and the read acknowledge are low, provided the read request is low.
- R2: Write layout: a beat sampled when a group's strobe goes from 0 to 1 is placed in the low half of the core word (`core_wr_data[g*GW +: GW]` for group g). The beat sampled when the strobe returns to 0 is placed in the high half (`core_wr_data[LANE_W + g*GW +: GW]`).
- R3: A group's write valid is a one-fast-cycle pulse. It rises two fast clock edges after the edge that sampled that group's falling strobe, which is one core clock later.
- R4: Write masks: `core_wr_mask[g]` carries group g's mask input from the first beat and `core_wr_mask[NBYTE+g]` carries it from the second beat. A 1 means that byte is not to be written.
- R5: Strobe groups are independent. A strobe pair on one group yields a word and valid on that group only, and the other group's valid stays low.
- R6: While `wr_window` is low, strobe transitions produce no write word. Dropping the window also clears the write word count of the current burst.
- R7: Within a write burst, `core_wr_last` is high only on the last of the burst's words. The burst-length code gives 0 = 1 word (BL2), 1 = 2 words (BL4), 2 and 3 = 4 words (BL8).
- R8: Read beats: the first beat of each word drives the low half of the word with the strobe at 1. The next fast cycle drives the high half with the strobe at 0. Data and strobe change together, and data enable is high for exactly 2 fast cycles per word.
- R9: Read framing: the edge that takes the first word starts exactly one preamble cycle, in which the strobe enable is 1 and the strobe and data enable are 0. After the last beat there is exactly one postamble cycle, in which the strobe enable is 1 and the strobe and data enable are 0. All enables are low in the cycle after that.
- R10: A read burst takes as many words as the burst-length code gives (same encoding as R7). `core_rd_ack` is high in each cycle whose closing edge latches `core_rd_data`.
- R11: The burst-length code is sampled only on the edge that takes the first read word. Changing it later in the burst does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the core rate |
| rst | input | 1 | Synchronous active-high reset |
| bl_sel | input | 2 | Burst-length code (see R7) |
| wr_window | input | 1 | Enables write capture |
| pin_dq_in | input | LANE_W (16) | Data beats from pins |
| pin_dm_in | input | NBYTE (2) | Per-group mask beats from pins |
| pin_dqs_in | input | NBYTE (2) | Per-group write strobes from pins |
| core_wr_data | output | 2*LANE_W (32) | Assembled write word |
| core_wr_mask | output | 2*NBYTE (4) | Mask of the word, per beat and group |
| core_wr_vld | output | NBYTE (2) | Per-group word-valid pulse |
| core_wr_last | output | NBYTE (2) | Word is the last of its burst |
| core_rd_data | input | 2*LANE_W (32) | Read word from core |
| core_rd_valid | input | 1 | Core requests a read burst |
| core_rd_ack | output | 1 | Word is taken at the coming edge |
| pin_dq_out | output | LANE_W (16) | Read data beats to pins |
| pin_dq_oe | output | 1 | Read data output enable |
| pin_dqs_out | output | NBYTE (2) | Read strobe, one copy per group |
| pin_dqs_oe | output | NBYTE (2) | Read strobe output enable |

## Verification
A wrong write word count shows at `core_wr_last`. The flag lands on the wrong word of the next burst, or on every word. This is visible within one burst of the fault, so the bench interleaves bursts of different lengths and drops the window partway through a burst. A lost or duplicated half-beat register shows as swapped or stale halves on the valid pulse two edges later. The read sequencer's state shows at the pins in every fast cycle: a skipped preamble or postamble, a beat count off by one, or a strobe level out of step with the data. The bench compares all enables, strobe and data on every cycle of each read burst.

// File: rtl/ddr_gb_pkg.sv
package ddr_gb_pkg;

    localparam int WPB_W = 3;

    typedef enum logic [2:0] {
        RS_IDLE = 3'd0,
        RS_PRE  = 3'd1,
        RS_B0   = 3'd2,
        RS_B1   = 3'd3,
        RS_POST = 3'd4
    } rd_state_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } beat_mask_t;

    // core words per burst for a burst-length code
    function automatic logic [WPB_W-1:0] words_per_burst(input logic [1:0] sel);
        case (sel)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/ddr_gb_wr_lane.sv
module ddr_gb_wr_lane
    import ddr_gb_pkg::*;
#(
    parameter int GW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                win,
    input  logic [WPB_W-1:0]    wpb,
    input  logic [GW-1:0]       dq,
    input  logic                dm,
    input  logic                dqs,
    output logic [2*GW-1:0]     out_d,
    output beat_mask_t          out_m,
    output logic                vld,
    output logic                last
);

    localparam logic [WPB_W-1:0] ONE = WPB_W'(1);

    logic              dqs_q;
    logic              have_lo;
    logic [GW-1:0]     lo_d, hi_d;
    logic              lo_m, hi_m;
    logic              p1, p2, last1, last2;
    logic [2*GW-1:0]   asm_d;
    beat_mask_t        asm_m;
    logic [WPB_W-1:0]  cnt;
    logic              rise, fall, cnt_end;

    assign rise    = dqs && !dqs_q;
    assign fall    = !dqs && dqs_q && have_lo;
    assign cnt_end = (cnt == wpb - ONE);

    // capture stage: one beat per strobe transition
    always_ff @(posedge clk) begin
        if (rst) begin
            dqs_q   <= 1'b0;
            have_lo <= 1'b0;
            lo_d    <= '0;
            hi_d    <= '0;
            lo_m    <= 1'b0;
            hi_m    <= 1'b0;
            p1      <= 1'b0;
            last1   <= 1'b0;
            cnt     <= '0;
        end else begin
            dqs_q <= dqs;
            p1    <= 1'b0;
            if (!win) begin
                have_lo <= 1'b0;
                cnt     <= '0;
            end else if (rise) begin
                lo_d    <= dq;
                lo_m    <= dm;
                have_lo <= 1'b1;
            end else if (fall) begin
                hi_d    <= dq;
                hi_m    <= dm;
                have_lo <= 1'b0;
                p1      <= 1'b1;
                last1   <= cnt_end;
                cnt     <= cnt_end ? '0 : cnt + ONE;
            end
        end
    end

    // assembly and output stages (core-clock alignment)
    always_ff @(posedge clk) begin
        if (rst) begin
            p2    <= 1'b0;
            asm_d <= '0;
            asm_m <= '0;
            last2 <= 1'b0;
            vld   <= 1'b0;
            out_d <= '0;
            out_m <= '0;
            last  <= 1'b0;
        end else begin
            p2 <= p1;
            if (p1) begin
                asm_d    <= {hi_d, lo_d};
                asm_m.hi <= hi_m;
                asm_m.lo <= lo_m;
                last2    <= last1;
            end
            vld <= p2;
            if (p2) begin
                out_d <= asm_d;
                out_m <= asm_m;
                last  <= last2;
            end
        end
    end

    AST_WR_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld);  // R3

    AST_WR_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        vld |-> $past(win, 3));  // R6

endmodule

// File: rtl/ddr_gb_rd_serdes.sv
module ddr_gb_rd_serdes
    import ddr_gb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bl_sel,
    input  logic [2*W-1:0]    rd_data,
    input  logic              rd_valid,
    output logic              rd_ack,
    output logic [W-1:0]      dq_out,
    output logic              dq_oe,
    output logic              dqs_out,
    output logic              dqs_oe
);

    localparam logic [WPB_W-1:0] ONE = WPB_W'(1);

    rd_state_e         st;
    logic [2*W-1:0]    word_q;
    logic [WPB_W-1:0]  wcnt, wpb_q;
    logic              last_w;

    assign last_w = (wcnt == wpb_q - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RS_IDLE;
            word_q <= '0;
            wcnt   <= '0;
            wpb_q  <= ONE;
        end else begin
            unique case (st)
                RS_IDLE: if (rd_valid) begin
                    word_q <= rd_data;
                    wpb_q  <= words_per_burst(bl_sel);
                    wcnt   <= '0;
                    st     <= RS_PRE;
                end
                RS_PRE:  st <= RS_B0;
                RS_B0:   st <= RS_B1;
                RS_B1: if (last_w) begin
                    st <= RS_POST;
                end else begin
                    word_q <= rd_data;
                    wcnt   <= wcnt + ONE;
                    st     <= RS_B0;
                end
                RS_POST: st <= RS_IDLE;
                default: st <= RS_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_ack  = ((st == RS_IDLE) && rd_valid) || ((st == RS_B1) && !last_w);
        dq_oe   = (st == RS_B0) || (st == RS_B1);
        dqs_oe  = (st != RS_IDLE);
        dqs_out = (st == RS_B0);
        dq_out  = (st == RS_B1) ? word_q[2*W-1:W] : word_q[W-1:0];
    end

    AST_RD_DQ_NEEDS_DQS: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> dqs_oe);  // R9

    AST_RD_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
        $rose(dqs_oe) |-> (!dqs_out && !dq_oe));  // R9

    AST_RD_POSTAMBLE: assert property (@(posedge clk) disable iff (rst)
        $fell(dq_oe) |-> (dqs_oe && !dqs_out));  // R9

    AST_RD_EDGE_PER_BEAT: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && $past(dq_oe)) |-> (dqs_out != $past(dqs_out)));  // R8

endmodule

// File: rtl/ddr_prefetch_gearbox.sv
module ddr_prefetch_gearbox
    import ddr_gb_pkg::*;
#(
    parameter int LANE_W = 16,
    localparam int NBYTE = (LANE_W + 7) / 8,
    localparam int GW    = LANE_W / NBYTE
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            bl_sel,
    input  logic                  wr_window,
    input  logic [LANE_W-1:0]     pin_dq_in,
    input  logic [NBYTE-1:0]      pin_dm_in,
    input  logic [NBYTE-1:0]      pin_dqs_in,
    output logic [2*LANE_W-1:0]   core_wr_data,
    output logic [2*NBYTE-1:0]    core_wr_mask,
    output logic [NBYTE-1:0]      core_wr_vld,
    output logic [NBYTE-1:0]      core_wr_last,
    input  logic [2*LANE_W-1:0]   core_rd_data,
    input  logic                  core_rd_valid,
    output logic                  core_rd_ack,
    output logic [LANE_W-1:0]     pin_dq_out,
    output logic                  pin_dq_oe,
    output logic [NBYTE-1:0]      pin_dqs_out,
    output logic [NBYTE-1:0]      pin_dqs_oe
);

    logic [WPB_W-1:0] wpb;
    logic             rd_dqs, rd_dqs_oe;

    assign wpb = words_per_burst(bl_sel);

    for (genvar g = 0; g < NBYTE; g++) begin : g_lane
        logic [2*GW-1:0] d;
        beat_mask_t      m;

        ddr_gb_wr_lane #(.GW(GW)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .win   (wr_window),
            .wpb   (wpb),
            .dq    (pin_dq_in[g*GW +: GW]),
            .dm    (pin_dm_in[g]),
            .dqs   (pin_dqs_in[g]),
            .out_d (d),
            .out_m (m),
            .vld   (core_wr_vld[g]),
            .last  (core_wr_last[g])
        );

        assign core_wr_data[g*GW +: GW]          = d[GW-1:0];
        assign core_wr_data[LANE_W + g*GW +: GW] = d[2*GW-1:GW];
        assign core_wr_mask[g]                   = m.lo;
        assign core_wr_mask[NBYTE + g]           = m.hi;
    end

    ddr_gb_rd_serdes #(.W(LANE_W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .bl_sel   (bl_sel),
        .rd_data  (core_rd_data),
        .rd_valid (core_rd_valid),
        .rd_ack   (core_rd_ack),
        .dq_out   (pin_dq_out),
        .dq_oe    (pin_dq_oe),
        .dqs_out  (rd_dqs),
        .dqs_oe   (rd_dqs_oe)
    );

    assign pin_dqs_out = {NBYTE{rd_dqs}};
    assign pin_dqs_oe  = {NBYTE{rd_dqs_oe}};

endmodule

// File: tb/ddr_prefetch_gearbox_tb_top.sv
module ddr_prefetch_gearbox_tb_top;

    localparam int CLK_P = 10;

    // {beat0[15:0], beat1[15:0], mask0[1:0], mask1[1:0]}
    localparam logic [35:0] TV [8] = '{
        {16'h1234, 16'hABCD, 2'b00, 2'b00},
        {16'h00FF, 16'hFF00, 2'b01, 2'b10},
        {16'hFFFF, 16'h0000, 2'b11, 2'b00},
        {16'h5A5A, 16'hA5A5, 2'b10, 2'b01},
        {16'h8001, 16'h7FFE, 2'b00, 2'b11},
        {16'hDEAD, 16'hBEEF, 2'b01, 2'b01},
        {16'h0F0F, 16'hF0F0, 2'b10, 2'b10},
        {16'hC3C3, 16'h3C3C, 2'b11, 2'b11}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bl_sel = 2'd0;
    logic        wr_window = 1'b0;
    logic [15:0] pin_dq_in = '0;
    logic [1:0]  pin_dm_in = '0;
    logic [1:0]  pin_dqs_in = '0;
    logic [31:0] core_wr_data;
    logic [3:0]  core_wr_mask;
    logic [1:0]  core_wr_vld, core_wr_last;
    logic [31:0] core_rd_data = '0;
    logic        core_rd_valid = 1'b0;
    logic        core_rd_ack;
    logic [15:0] pin_dq_out;
    logic        pin_dq_oe;
    logic [1:0]  pin_dqs_out, pin_dqs_oe;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    int          mon_n [2] = '{0, 0};
    logic [15:0] mdat  [2][32];
    logic        mlast [2][32];

    always #(CLK_P/2) clk = ~clk;

    ddr_prefetch_gearbox #(.LANE_W(16)) dut_i (
        .clk(clk), .rst(rst), .bl_sel(bl_sel), .wr_window(wr_window),
        .pin_dq_in(pin_dq_in), .pin_dm_in(pin_dm_in), .pin_dqs_in(pin_dqs_in),
        .core_wr_data(core_wr_data), .core_wr_mask(core_wr_mask),
        .core_wr_vld(core_wr_vld), .core_wr_last(core_wr_last),
        .core_rd_data(core_rd_data), .core_rd_valid(core_rd_valid),
        .core_rd_ack(core_rd_ack), .pin_dq_out(pin_dq_out), .pin_dq_oe(pin_dq_oe),
        .pin_dqs_out(pin_dqs_out), .pin_dqs_oe(pin_dqs_oe)
    );

    // record every write word per group
    always @(negedge clk) begin
        for (int g = 0; g < 2; g++) begin
            if (core_wr_vld[g] && mon_n[g] < 32) begin
                mdat[g][mon_n[g]]  = {core_wr_data[16 + g*8 +: 8], core_wr_data[g*8 +: 8]};
                mlast[g][mon_n[g]] = core_wr_last[g];
                mon_n[g]           = mon_n[g] + 1;
            end
        end
    end

    function automatic logic [15:0] tv_d0(input int i); return TV[i % 8][35:20]; endfunction
    function automatic logic [15:0] tv_d1(input int i); return TV[i % 8][19:4];  endfunction
    function automatic logic [1:0]  tv_m0(input int i); return TV[i % 8][3:2];   endfunction
    function automatic logic [1:0]  tv_m1(input int i); return TV[i % 8][1:0];   endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) act=%0d exp<20000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic drive_word(input logic [15:0] d0, input logic [15:0] d1,
                              input logic [1:0] m0, input logic [1:0] m1, input logic [1:0] gm);
        @(negedge clk);
        pin_dq_in = d0; pin_dm_in = m0; pin_dqs_in = gm;
        @(negedge clk);
        pin_dq_in = d1; pin_dm_in = m1; pin_dqs_in = 2'b00;
    endtask

    // single BL2 word, checks timing, layout, masks and last
    task automatic wr_single(input int i, input logic [1:0] gm);
        drive_word(tv_d0(i), tv_d1(i), tv_m0(i), tv_m1(i), gm);
        @(negedge clk);
        chk("R3 vld low 1 edge after fall", core_wr_vld, 2'b00);
        @(negedge clk);
        chk("R3 vld low 2nd edge", core_wr_vld, 2'b00);
        @(negedge clk);
        chk("R3 vld pulse", core_wr_vld, gm);
        if (gm == 2'b11) begin
            chk("R2 word layout", core_wr_data, {tv_d1(i), tv_d0(i)});
            chk("R4 mask layout", core_wr_mask, {tv_m1(i), tv_m0(i)});
            chk("R7 BL2 last", core_wr_last, 2'b11);
        end else begin
            chk("R5 upper group bytes", {core_wr_data[31:24], core_wr_data[15:8]},
                {tv_d1(i)[15:8], tv_d0(i)[15:8]});
        end
        @(negedge clk);
        chk("R3 vld one cycle", core_wr_vld, 2'b00);
    endtask

    task automatic rd_burst(input logic [1:0] sel, input int nw, input int base,
                            input bit chg, input string tag);
        int  taken = 0;
        int  acks  = 0;
        bit  took;
        @(negedge clk);
        bl_sel        = sel;
        core_rd_data  = {tv_d1(base), tv_d0(base)};
        core_rd_valid = 1'b1;
        #1;
        took = core_rd_ack;
        if (took) acks++;
        for (int j = 0; j <= 2*nw + 2; j++) begin
            logic [20:0] a, e;
            logic        eoe;
            logic [1:0]  eso, es;
            logic [15:0] ed;
            string       tg;
            @(negedge clk);
            if (took) begin
                taken++;
                if (taken < nw) core_rd_data = {tv_d1(base + taken), tv_d0(base + taken)};
                else            core_rd_valid = 1'b0;
            end
            if (chg && j == 0) bl_sel = 2'd0;
            if (j == 0) begin
                eoe = 0; eso = 2'b11; es = 2'b00; ed = '0; tg = "R9 preamble";
            end else if (j <= 2*nw) begin
                int i = (j - 1) / 2;
                eoe = 1; eso = 2'b11;
                if (j % 2 == 1) begin es = 2'b11; ed = tv_d0(base + i); end
                else            begin es = 2'b00; ed = tv_d1(base + i); end
                tg = "R8 beat";
            end else if (j == 2*nw + 1) begin
                eoe = 0; eso = 2'b11; es = 2'b00; ed = '0; tg = "R9 postamble";
            end else begin
                eoe = 0; eso = 2'b00; es = 2'b00; ed = '0; tg = "R9 idle after";
            end
            a = {pin_dq_oe, pin_dqs_oe, pin_dqs_out, pin_dq_oe ? pin_dq_out : 16'h0};
            e = {eoe, eso, es, ed};
            chk(tg, a, e);
            #1;
            took = core_rd_ack;
            if (took) acks++;
        end
        chk({tag, " words per burst"}, acks, nw);
    endtask

    initial begin
        int b0, b1;
        repeat (2) @(negedge clk);
        chk("R1 reset enables", {pin_dq_oe, pin_dqs_oe}, 3'b000);
        chk("R1 reset vld/ack", {core_wr_vld, core_rd_ack}, 3'b000);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {pin_dq_oe, pin_dqs_oe, core_wr_vld, core_rd_ack}, 6'b0);

        // table walk: write BL2 and read BL2 per vector
        wr_window = 1'b1;
        bl_sel    = 2'd0;
        for (int i = 0; i < 8; i++) begin
            wr_single(i, 2'b11);
            rd_burst(2'd0, 1, i, 1'b0, "R10 BL2");
        end

        // R5: only group 1 strobes
        b0 = mon_n[0];
        wr_single(3, 2'b10);
        chk("R5 group0 silent", mon_n[0] - b0, 0);

        // R7: BL8 write burst
        bl_sel = 2'd2;
        b0 = mon_n[0]; b1 = mon_n[1];
        for (int i = 0; i < 4; i++)
            drive_word(tv_d0(i), tv_d1(i), tv_m0(i), tv_m1(i), 2'b11);
        repeat (5) @(negedge clk);
        chk("R7 BL8 g0 count", mon_n[0] - b0, 4);
        chk("R7 BL8 g1 count", mon_n[1] - b1, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R2 BL8 g0 word", mdat[0][(b0 + i) % 32], {tv_d1(i)[7:0], tv_d0(i)[7:0]});
            chk("R7 BL8 last flag", mlast[0][(b0 + i) % 32], (i == 3));
        end

        // R6: window low ignores strobes
        wr_window = 1'b0;
        b0 = mon_n[0]; b1 = mon_n[1];
        drive_word(16'h1111, 16'h2222, 2'b00, 2'b00, 2'b11);
        drive_word(16'h3333, 16'h4444, 2'b00, 2'b00, 2'b11);
        repeat (5) @(negedge clk);
        chk("R6 no word while window low", (mon_n[0] - b0) + (mon_n[1] - b1), 0);

        // R6: dropping window restarts burst count (BL4)
        bl_sel    = 2'd1;
        wr_window = 1'b1;
        b0 = mon_n[0];
        drive_word(tv_d0(5), tv_d1(5), 2'b00, 2'b00, 2'b11);
        repeat (5) @(negedge clk);
        wr_window = 1'b0;
        repeat (2) @(negedge clk);
        wr_window = 1'b1;
        drive_word(tv_d0(6), tv_d1(6), 2'b00, 2'b00, 2'b11);
        drive_word(tv_d0(7), tv_d1(7), 2'b00, 2'b00, 2'b11);
        repeat (5) @(negedge clk);
        chk("R6 count words", mon_n[0] - b0, 3);
        chk("R6 partial word not last", mlast[0][b0 % 32], 1'b0);
        chk("R6 restarted burst word1 not last", mlast[0][(b0 + 1) % 32], 1'b0);
        chk("R7 restarted burst word2 last", mlast[0][(b0 + 2) % 32], 1'b1);

        // read burst lengths
        rd_burst(2'd1, 2, 2, 1'b0, "R10 BL4");
        rd_burst(2'd3, 4, 4, 1'b0, "R10 code3");
        rd_burst(2'd2, 4, 1, 1'b1, "R11 BL8 code changed");
        rd_burst(2'd0, 1, 6, 1'b0, "R10 BL2 after BL8");

        summary();
        $finish;
    end

endmodule